// File: doc/BRIEF.md
# GPIO Edge Interrupt Controller

This block is a register-mapped controller for eleven general-purpose pins on a simple memory-mapped bus. The bus uses word addresses and carries a write strobe, write data and combinational read data. Four 32-bit registers set each pin's direction and output level, enable a per-pin interrupt, and show the level of the pins in input mode. Only bits 10:0 of each register are used. The block drives an output vector and a direction vector toward the pad cells and samples the pad inputs through a two-flop synchroniser.

Each pin has a small state machine with three states:

- `PIN_OFF`: the pin's interrupt is disabled, or the pin is an output.
- `PIN_ARMED`: the pin is an input with its interrupt enabled, and the machine waits for a rising edge.
- `PIN_PENDING`: a rising edge was seen, and the pending flag stays set.

The transitions are:

- **arm** (`PIN_OFF` to `PIN_ARMED`): the enable bit is 1 and the direction bit is 0.
- **disarm** (`PIN_ARMED` to `PIN_OFF`): the enable bit drops to 0 or the pin becomes an output.
- **capture** (`PIN_ARMED` to `PIN_PENDING`): a synchronised rising edge arrives.
- **release** (`PIN_PENDING` to `PIN_OFF`): software writes 0 to the pin's enable bit.

The single interrupt line is the OR of all pending flags. Software clears a pin's interrupt by clearing that pin's enable bit. There is no separate status or clear register.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset all four registers read zero, `pad_oe`, `pad_out` and `irq` are 0, and every pin is an input with its interrupt disabled.
- R2: The direction register is at word address 0x1E (byte offset 0x78). A written value is read back on bits 10:0 and appears on `pad_oe` after the write clock edge; a 1 bit makes that pin an output.
- R3: The output-value register is at word address 0x22 (byte offset 0x88). A read returns the last written bits 10:0 whatever the direction. The value appears on `pad_out` after the write clock edge.
- R4: The input register is at word address 0x20 (byte offset 0x80). Bit i shows the pad level of pin i after two clock edges of synchronisation when direction bit i is 0, and reads 0 when the pin is an output. A write to this address changes no register and no output.
- R5: The interrupt-enable register is at word address 0x24 (byte offset 0x90) and reads back its last written bits 10:0.
- R6: A rising pad edge on an armed pin (enable 1, direction 0, held for at least one cycle) raises `irq` after the third clock edge following the pad change. `irq` stays high after the pad falls again (sticky).
- R7: No pending state comes from a pin in output mode, from a pin with its enable bit at 0, or from a falling edge.
- R8: Writing 0 to a pending pin's enable bit clears its pending state. With no other pin pending, `irq` is still 1 after the write edge and is 0 after the next edge.
- R9: Bits 31:11 of every read are 0, and any unmapped word address reads 0 and ignores writes.
- R10: `irq` is the OR over all pins. While one pin stays pending, clearing another pin's enable bit leaves `irq` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 6 | Word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pad_in | input | 11 | Pad input levels (asynchronous) |
| pad_out | output | 11 | Output levels toward the pads |
| pad_oe | output | 11 | Per-pin output enable toward the pads |
| irq | output | 1 | Combined rising-edge interrupt |

## Verification
The bench builds the block with its default parameters: 11 pins, a 32-bit data path, 6-bit word addresses and the register addresses 0x1E, 0x20, 0x22 and 0x24. With these values, all-ones writes reach bits 31:11, so the masking of unused bits is exercised. Pins set to different directions and different enable bits in one pattern show that an output-mode pin, a disabled pin and a falling edge stay silent while an armed pin next to them captures. Because there are eleven pins, two pins can be pending together, which shows the OR behaviour and a clear of one pin while the other keeps `irq` high.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    localparam int unsigned GPIO_PINS   = 11;
    localparam int unsigned GPIO_DATA_W = 32;
    localparam int unsigned GPIO_ADDR_W = 6;

    // Word addresses (byte offset divided by four)
    localparam logic [GPIO_ADDR_W-1:0] GPIO_OE_WADDR  = 6'h1E;
    localparam logic [GPIO_ADDR_W-1:0] GPIO_IN_WADDR  = 6'h20;
    localparam logic [GPIO_ADDR_W-1:0] GPIO_OUT_WADDR = 6'h22;
    localparam logic [GPIO_ADDR_W-1:0] GPIO_IE_WADDR  = 6'h24;

    typedef enum logic [1:0] {
        PIN_OFF     = 2'd0,
        PIN_ARMED   = 2'd1,
        PIN_PENDING = 2'd2
    } pin_state_e;

    typedef enum logic [2:0] {
        SEL_NONE = 3'd0,
        SEL_OE   = 3'd1,
        SEL_IN   = 3'd2,
        SEL_OUT  = 3'd3,
        SEL_IE   = 3'd4
    } reg_sel_e;

endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
    parameter int unsigned WIDTH = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] level_q,
    output logic [WIDTH-1:0] rise
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stage_q;
    logic [WIDTH-1:0] hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q  <= '0;
            stage_q <= '0;
            hist_q  <= '0;
        end else begin
            meta_q  <= async_in;
            stage_q <= meta_q;
            hist_q  <= stage_q;
        end
    end

    assign level_q = stage_q;
    assign rise    = stage_q & ~hist_q;

endmodule

// File: rtl/gpio_pin_irq_fsm.sv
module gpio_pin_irq_fsm
    import gpio_edge_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic int_en,
    input  logic dir_out,
    input  logic rise,
    output logic pending
);

    pin_state_e state_q;
    pin_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PIN_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PIN_OFF: begin
                if (int_en && !dir_out) begin
                    state_d = PIN_ARMED;          // arm
                end
            end
            PIN_ARMED: begin
                if (!int_en || dir_out) begin
                    state_d = PIN_OFF;            // disarm
                end else if (rise) begin
                    state_d = PIN_PENDING;        // capture
                end
            end
            PIN_PENDING: begin
                if (!int_en) begin
                    state_d = PIN_OFF;            // release
                end
            end
            default: state_d = PIN_OFF;
        endcase
    end

    always_comb begin
        pending = 1'b0;
        unique case (state_q)
            PIN_OFF:     pending = 1'b0;
            PIN_ARMED:   pending = 1'b0;
            PIN_PENDING: pending = 1'b1;
            default:     pending = 1'b0;
        endcase
    end

endmodule

// File: rtl/gpio_reg_bank.sv
module gpio_reg_bank
    import gpio_edge_pkg::*;
#(
    parameter int unsigned         PINS     = GPIO_PINS,
    parameter int unsigned         DATA_W   = GPIO_DATA_W,
    parameter int unsigned         ADDR_W   = GPIO_ADDR_W,
    parameter logic [ADDR_W-1:0]   OE_ADDR  = GPIO_OE_WADDR,
    parameter logic [ADDR_W-1:0]   IN_ADDR  = GPIO_IN_WADDR,
    parameter logic [ADDR_W-1:0]   OUT_ADDR = GPIO_OUT_WADDR,
    parameter logic [ADDR_W-1:0]   IE_ADDR  = GPIO_IE_WADDR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [PINS-1:0]   wbits,
    input  logic [PINS-1:0]   pad_level,
    output logic [DATA_W-1:0] rdata,
    output logic [PINS-1:0]   oe_q,
    output logic [PINS-1:0]   out_q,
    output logic [PINS-1:0]   ie_q
);

    localparam int unsigned PAD_W = DATA_W - PINS;

    reg_sel_e        sel;
    logic [PINS-1:0] rd_bits;

    always_comb begin
        if (addr == OE_ADDR) begin
            sel = SEL_OE;
        end else if (addr == IN_ADDR) begin
            sel = SEL_IN;
        end else if (addr == OUT_ADDR) begin
            sel = SEL_OUT;
        end else if (addr == IE_ADDR) begin
            sel = SEL_IE;
        end else begin
            sel = SEL_NONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_q  <= '0;
            out_q <= '0;
            ie_q  <= '0;
        end else if (we) begin
            unique case (sel)
                SEL_OE:   oe_q  <= wbits;
                SEL_OUT:  out_q <= wbits;
                SEL_IE:   ie_q  <= wbits;
                SEL_IN:   ;
                SEL_NONE: ;
                default:  ;
            endcase
        end
    end

    always_comb begin
        rd_bits = '0;
        unique case (sel)
            SEL_OE:   rd_bits = oe_q;
            SEL_IN:   rd_bits = pad_level & ~oe_q;
            SEL_OUT:  rd_bits = out_q;
            SEL_IE:   rd_bits = ie_q;
            SEL_NONE: rd_bits = '0;
            default:  rd_bits = '0;
        endcase
    end

    assign rdata = {{PAD_W{1'b0}}, rd_bits};

endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
    import gpio_edge_pkg::*;
#(
    parameter int unsigned       PINS     = GPIO_PINS,
    parameter int unsigned       DATA_W   = GPIO_DATA_W,
    parameter int unsigned       ADDR_W   = GPIO_ADDR_W,
    parameter logic [ADDR_W-1:0] OE_ADDR  = GPIO_OE_WADDR,
    parameter logic [ADDR_W-1:0] IN_ADDR  = GPIO_IN_WADDR,
    parameter logic [ADDR_W-1:0] OUT_ADDR = GPIO_OUT_WADDR,
    parameter logic [ADDR_W-1:0] IE_ADDR  = GPIO_IE_WADDR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_out,
    output logic [PINS-1:0]   pad_oe,
    output logic              irq
);

    logic [PINS-1:0] level_q;
    logic [PINS-1:0] rise;
    logic [PINS-1:0] oe_q;
    logic [PINS-1:0] out_q;
    logic [PINS-1:0] ie_q;
    logic [PINS-1:0] pend;

    gpio_pad_sync #(.WIDTH(PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .level_q  (level_q),
        .rise     (rise)
    );

    gpio_reg_bank #(
        .PINS     (PINS),
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .OE_ADDR  (OE_ADDR),
        .IN_ADDR  (IN_ADDR),
        .OUT_ADDR (OUT_ADDR),
        .IE_ADDR  (IE_ADDR)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (bus_addr),
        .we        (bus_we),
        .wbits     (bus_wdata[PINS-1:0]),
        .pad_level (level_q),
        .rdata     (bus_rdata),
        .oe_q      (oe_q),
        .out_q     (out_q),
        .ie_q      (ie_q)
    );

    for (genvar p = 0; p < PINS; p++) begin : g_pin
        gpio_pin_irq_fsm u_fsm (
            .clk     (clk),
            .rst_n   (rst_n),
            .int_en  (ie_q[p]),
            .dir_out (oe_q[p]),
            .rise    (rise[p]),
            .pending (pend[p])
        );
    end

    assign pad_out = out_q;
    assign pad_oe  = oe_q;
    assign irq     = |pend;

endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk #(
    parameter int unsigned       PINS     = 11,
    parameter int unsigned       DATA_W   = 32,
    parameter int unsigned       ADDR_W   = 6,
    parameter logic [ADDR_W-1:0] OE_ADDR  = 6'h1E,
    parameter logic [ADDR_W-1:0] IN_ADDR  = 6'h20,
    parameter logic [ADDR_W-1:0] OUT_ADDR = 6'h22,
    parameter logic [ADDR_W-1:0] IE_ADDR  = 6'h24
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [PINS-1:0]   pad_out,
    input logic [PINS-1:0]   pad_oe,
    input logic              irq,
    input logic [PINS-1:0]   ie_q
);

    AST_OE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OE_ADDR) |=> (pad_oe == $past(bus_wdata[PINS-1:0]))); // R2

    AST_OUT_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OUT_ADDR) |=> (pad_out == $past(bus_wdata[PINS-1:0]))); // R3

    AST_INPUT_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == IN_ADDR) |=> ($stable(pad_oe) && $stable(pad_out) && $stable(ie_q))); // R4

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(ie_q) != '0)); // R7

    AST_IRQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == IE_ADDR && bus_wdata[PINS-1:0] == '0) |=> ##1 !irq); // R8

    AST_UPPER_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:PINS] == '0); // R9

endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(
    .PINS     (PINS),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .OE_ADDR  (OE_ADDR),
    .IN_ADDR  (IN_ADDR),
    .OUT_ADDR (OUT_ADDR),
    .IE_ADDR  (IE_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .irq       (irq),
    .ie_q      (ie_q)
);

// File: tb/test_gpio_edge_ctrl.sv
`timescale 1ns/1ps
module test_gpio_edge_ctrl;

    localparam logic [5:0] A_OE  = 6'h1E;
    localparam logic [5:0] A_IN  = 6'h20;
    localparam logic [5:0] A_OUT = 6'h22;
    localparam logic [5:0] A_IE  = 6'h24;
    localparam logic [5:0] A_NA0 = 6'h00;
    localparam logic [5:0] A_NA1 = 6'h10;

    typedef struct packed {
        logic [5:0]  waddr;
        logic [31:0] wdata;
        logic [5:0]  raddr;
        logic [31:0] rexp;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{A_OE,  32'hFFFF_FFFF, A_OE,  32'h0000_07FF},  // R2 R9
        '{A_OUT, 32'h0000_0555, A_OUT, 32'h0000_0555},  // R3
        '{A_OUT, 32'hABCD_E2AA, A_OUT, 32'h0000_02AA},  // R3 R9
        '{A_IE,  32'h0000_0123, A_IE,  32'h0000_0123},  // R5
        '{A_OE,  32'h0000_000F, A_OE,  32'h0000_000F},  // R2
        '{A_IN,  32'h0000_07FF, A_OE,  32'h0000_000F},  // R4 write ignored
        '{A_NA0, 32'h0000_07FF, A_OUT, 32'h0000_02AA},  // R9 unmapped write ignored
        '{A_OE,  32'h0000_0000, A_NA1, 32'h0000_0000},  // R9 unmapped reads 0
        '{A_IE,  32'h0000_0000, A_IE,  32'h0000_0000},  // R5
        '{A_OUT, 32'h0000_0000, A_OUT, 32'h0000_0000}   // R3
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [10:0] pad_in = '0;
    logic [10:0] pad_out;
    logic [10:0] pad_oe;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_edge_ctrl i_gpio_edge_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [31:0] rd;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(A_OE, rd);  chk("R1 oe reg", rd, 32'h0);
        bus_read(A_OUT, rd); chk("R1 out reg", rd, 32'h0);
        bus_read(A_IE, rd);  chk("R1 ie reg", rd, 32'h0);
        bus_read(A_IN, rd);  chk("R1 in reg", rd, 32'h0);
        chk("R1 pad_oe", {21'h0, pad_oe}, 32'h0);
        chk("R1 pad_out", {21'h0, pad_out}, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);

        // Register table walk (R2 R3 R4 R5 R9)
        for (int i = 0; i < NVEC; i++) begin
            bus_write(VECS[i].waddr, VECS[i].wdata);
            bus_read(VECS[i].raddr, rd);
            chk($sformatf("vector %0d (R2/R3/R4/R5/R9 table)", i), rd, VECS[i].rexp);
        end

        // R2 R3 pads follow registers
        bus_write(A_OE, 32'h0000_03C0);
        chk("R2 pad_oe", {21'h0, pad_oe}, 32'h0000_03C0);
        bus_write(A_OUT, 32'h0000_0155);
        chk("R3 pad_out", {21'h0, pad_out}, 32'h0000_0155);
        bus_read(A_OUT, rd);
        chk("R3 readback with mixed direction", rd, 32'h0000_0155);

        // R4 synchronised input, output pins masked
        pad_in = 11'h7FF;
        wait_cyc(1);
        bus_read(A_IN, rd); chk("R4 in after one edge", rd, 32'h0);
        wait_cyc(1);
        bus_read(A_IN, rd); chk("R4 in after two edges", rd, 32'h0000_043F);

        // R7 no capture from output pin, falling edge, or disabled pin
        pad_in = 11'h004;
        bus_write(A_OE, 32'h0000_0002);
        wait_cyc(3);
        bus_write(A_IE, 32'h0000_0006);
        wait_cyc(3);
        pad_in = 11'h00A;
        wait_cyc(5);
        chk("R7 irq stays low", {31'h0, irq}, 32'h0);

        // R6 capture timing and stickiness
        bus_write(A_IE, 32'h0);
        pad_in = 11'h000;
        bus_write(A_OE, 32'h0);
        bus_write(A_IE, 32'h0000_0005);
        wait_cyc(4);
        pad_in = 11'h001;
        wait_cyc(2);
        chk("R6 irq low after two edges", {31'h0, irq}, 32'h0);
        wait_cyc(1);
        chk("R6 irq high after third edge", {31'h0, irq}, 32'h1);
        pad_in = 11'h000;
        wait_cyc(3);
        chk("R6 irq sticky after pad falls", {31'h0, irq}, 32'h1);

        // R10 two pending pins, clear one
        pad_in = 11'h004;
        wait_cyc(4);
        bus_write(A_IE, 32'h0000_0004);
        wait_cyc(3);
        chk("R10 irq held by remaining pin", {31'h0, irq}, 32'h1);

        // R8 release timing
        bus_write(A_IE, 32'h0);
        chk("R8 irq still high after write edge", {31'h0, irq}, 32'h1);
        wait_cyc(1);
        chk("R8 irq low one edge later", {31'h0, irq}, 32'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule